// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Controller

This block keeps the status register of a small serial memory and decides, for every write attempt, whether it may go ahead. It receives instruction codes that an upstream serial front end has already assembled. It also receives the level of an external active-low write-protect pin and array write requests that carry a word address. A one-cycle accept or reject pulse answers each write attempt. The current status byte is always visible for reads.

The register holds two kinds of state. The volatile state is a write-enable latch and a general-purpose flag, and both clear at reset. The persistent state is a two-bit block-lock code, a two-bit watchdog period code and a protect-enable bit. These load at reset from an input that stands in for nonvolatile cells.

The block-lock code guards an upper portion of the array against writes. Reads are never affected. When the pin is low and protect-enable is set, status writes are refused, which freezes the lock and watchdog settings. Every write also needs the write-enable latch, and the latch drops after each attempt.

Top module: `mem_stat_ctrl`

## Requirements
- R1: While reset is asserted, status_o reads protect-enable = nv_init_i[4], watchdog = nv_init_i[3:2], block-lock = nv_init_i[1:0], and flag and write-enable latch read 0. Both response pulse pairs stay 0.
- R2: The status byte layout is protect-enable at bit 7, watchdog code at bits 5:4, block-lock code at bits 3:2, flag at bit 1 and write-enable latch at bit 0. Bits 6 always reads 0.
- R3: Op 0x06 sets the write-enable latch and op 0x04 clears it. An op code that is not listed here or in R4 and R7 changes no state.
- R4: Op 0x3A sets the flag and op 0x3B clears it. No other op and no write changes the flag.
- R5: Block-lock code 00 protects no address. Code 01 protects the top quarter of the address space (two address MSBs = 11). Code 10 protects the top half (address MSB = 1). Code 11 protects every address.
- R6: An array write request is accepted when the latch is 1 and the address is unprotected. Otherwise it is rejected. Exactly one of arr_wr_ok_o and arr_wr_rej_o pulses in the cycle after the request.
- R7: Op 0x01 is a status write. It is accepted when the latch is 1 and not (wp_ni = 0 and protect-enable = 1). An accepted status write loads protect-enable from data bit 7, watchdog from data bits 5:4 and block-lock from data bits 3:2. A rejected status write changes none of these bits. The response pulses in the cycle after the op.
- R8: The write-enable latch reads 0 after every array or status write attempt, whether it was accepted or rejected. Status write data never sets the latch or the flag.
- R9: When an array write request and a command arrive in the same cycle, the command is ignored.
- R10: Protect-enable, watchdog and block-lock change only in a cycle where sr_wr_ok_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nv_init_i | input | 5 | Persistent power-up values {protect-enable, watchdog[1:0], block-lock[1:0]} |
| cmd_valid_i | input | 1 | Command strobe for one cycle |
| cmd_op_i | input | 8 | Instruction code |
| cmd_data_i | input | 8 | Status write data |
| wp_ni | input | 1 | Write-protect pin, active low |
| arr_wr_req_i | input | 1 | Array write request strobe |
| arr_addr_i | input | ADDR_W | Array write address |
| arr_wr_ok_o | output | 1 | Array write accepted |
| arr_wr_rej_o | output | 1 | Array write rejected |
| sr_wr_ok_o | output | 1 | Status write accepted |
| sr_wr_rej_o | output | 1 | Status write rejected |
| status_o | output | 8 | Status byte |

## Verification
The bench builds the block with ADDR_W = 6. That makes the whole 64-word space small enough to sweep for each of the four block-lock codes, with the write-enable latch both set and clear. Because of that sweep, every protection boundary is exercised, not only its end points. All eight combinations of pin level, protect-enable and latch are also applied to status writes. The data for those writes carries junk in the unused and volatile bit positions, so the bench can check that only the persistent fields load.

// File: rtl/mem_stat_pkg.sv
package mem_stat_pkg;
  localparam int OP_W   = 8;
  localparam int DATA_W = 8;
  localparam int NV_W   = 5;

  localparam logic [OP_W-1:0] OP_WEN   = 8'h06;
  localparam logic [OP_W-1:0] OP_WDIS  = 8'h04;
  localparam logic [OP_W-1:0] OP_WSTAT = 8'h01;
  localparam logic [OP_W-1:0] OP_FSET  = 8'h3A;
  localparam logic [OP_W-1:0] OP_FCLR  = 8'h3B;

  typedef struct packed {
    logic wen;
    logic wdis;
    logic wstat;
    logic fset;
    logic fclr;
  } op_dec_t;

  typedef struct packed {
    logic       prot_en;
    logic [1:0] wdog;
    logic [1:0] blk;
  } nv_bits_t;
endpackage

// File: rtl/mst_op_decode.sv
module mst_op_decode
  import mem_stat_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output op_dec_t         dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.wen   = valid_i && (op_i == OP_WEN);
    dec_o.wdis  = valid_i && (op_i == OP_WDIS);
    dec_o.wstat = valid_i && (op_i == OP_WSTAT);
    dec_o.fset  = valid_i && (op_i == OP_FSET);
    dec_o.fclr  = valid_i && (op_i == OP_FCLR);
  end
endmodule

// File: rtl/mst_blk_guard.sv
module mst_blk_guard #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        blk_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] msb2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign msb2 = addr_i[TOP -: 2];
    end else begin : g_narrow
      assign msb2 = {addr_i[0], addr_i[0]};
    end
  endgenerate

  // code selects quarter, half or whole of the space from the top down
  always_comb begin
    unique case (blk_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = (msb2 == 2'b11);
      2'b10:   prot_o = msb2[1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mst_stat_regs.sv
module mst_stat_regs
  import mem_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NV_W-1:0]   nv_init_i,
  input  op_dec_t           dec_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_ni,
  input  logic              arr_req_i,
  input  logic              arr_prot_i,
  output logic              arr_ok_o,
  output logic              arr_rej_o,
  output logic              sr_ok_o,
  output logic              sr_rej_o,
  output logic [DATA_W-1:0] status_o
);
  nv_bits_t nv_q, nv_d, nv_rst;
  logic     wel_q, wel_d;
  logic     flag_q, flag_d;
  logic     cmd_en, sr_try, sr_allow, arr_allow;

  assign nv_rst    = nv_bits_t'(nv_init_i);
  assign cmd_en    = !arr_req_i;
  assign sr_try    = cmd_en && dec_i.wstat;
  assign sr_allow  = wel_q && !(nv_q.prot_en && !wp_ni);
  assign arr_allow = wel_q && !arr_prot_i;

  always_comb begin
    wel_d  = wel_q;
    flag_d = flag_q;
    nv_d   = nv_q;
    if (arr_req_i || sr_try) begin
      wel_d = 1'b0;
    end else if (dec_i.wen) begin
      wel_d = 1'b1;
    end else if (dec_i.wdis) begin
      wel_d = 1'b0;
    end
    if (cmd_en && dec_i.fset) flag_d = 1'b1;
    if (cmd_en && dec_i.fclr) flag_d = 1'b0;
    if (sr_try && sr_allow) begin
      nv_d.prot_en = data_i[7];
      nv_d.wdog    = data_i[5:4];
      nv_d.blk     = data_i[3:2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q      <= nv_rst;
      wel_q     <= 1'b0;
      flag_q    <= 1'b0;
      arr_ok_o  <= 1'b0;
      arr_rej_o <= 1'b0;
      sr_ok_o   <= 1'b0;
      sr_rej_o  <= 1'b0;
    end else begin
      nv_q      <= nv_d;
      wel_q     <= wel_d;
      flag_q    <= flag_d;
      arr_ok_o  <= arr_req_i && arr_allow;
      arr_rej_o <= arr_req_i && !arr_allow;
      sr_ok_o   <= sr_try && sr_allow;
      sr_rej_o  <= sr_try && !sr_allow;
    end
  end

  assign status_o = {nv_q.prot_en, 1'b0, nv_q.wdog, nv_q.blk, flag_q, wel_q};
endmodule

// File: rtl/mem_stat_ctrl.sv
module mem_stat_ctrl
  import mem_stat_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        nv_init_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              wp_ni,
  input  logic              arr_wr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic              arr_wr_ok_o,
  output logic              arr_wr_rej_o,
  output logic              sr_wr_ok_o,
  output logic              sr_wr_rej_o,
  output logic [7:0]        status_o
);
  op_dec_t dec;
  logic    arr_prot;

  mst_op_decode i_dec (
    .valid_i (cmd_valid_i),
    .op_i    (cmd_op_i),
    .dec_o   (dec)
  );

  mst_blk_guard #(.ADDR_W(ADDR_W)) i_guard (
    .blk_i  (status_o[3:2]),
    .addr_i (arr_addr_i),
    .prot_o (arr_prot)
  );

  mst_stat_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nv_init_i  (nv_init_i),
    .dec_i      (dec),
    .data_i     (cmd_data_i),
    .wp_ni      (wp_ni),
    .arr_req_i  (arr_wr_req_i),
    .arr_prot_i (arr_prot),
    .arr_ok_o   (arr_wr_ok_o),
    .arr_rej_o  (arr_wr_rej_o),
    .sr_ok_o    (sr_wr_ok_o),
    .sr_rej_o   (sr_wr_rej_o),
    .status_o   (status_o)
  );
endmodule

// File: rtl/mem_stat_ctrl_chk.sv
module mem_stat_ctrl_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              wp_ni,
  input logic              arr_wr_req_i,
  input logic [ADDR_W-1:0] arr_addr_i,
  input logic              arr_wr_ok_o,
  input logic              arr_wr_rej_o,
  input logic              sr_wr_ok_o,
  input logic              sr_wr_rej_o,
  input logic [7:0]        status_o
);
  AST_ARR_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_req_i |=> $countones({arr_wr_ok_o, arr_wr_rej_o}) == 1); // R6
  AST_ARR_OK_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_ok_o |-> $past(status_o[0])); // R6
  AST_SR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_ok_o |-> $past(status_o[0]) && !($past(status_o[7]) && !$past(wp_ni))); // R7
  AST_WEL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_ok_o || arr_wr_rej_o || sr_wr_ok_o || sr_wr_rej_o) |-> !status_o[0]); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cmd_valid_i) || $past(arr_wr_req_i)) |-> $stable(status_o[1])); // R4
  AST_PERSIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_ok_o |-> $stable(status_o[7:2])); // R10
  AST_BIT6_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[6]); // R2
  AST_SR_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sr_wr_ok_o, sr_wr_rej_o, arr_wr_ok_o || arr_wr_rej_o})); // R9
endmodule

bind mem_stat_ctrl mem_stat_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .wp_ni        (wp_ni),
  .arr_wr_req_i (arr_wr_req_i),
  .arr_addr_i   (arr_addr_i),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .arr_wr_rej_o (arr_wr_rej_o),
  .sr_wr_ok_o   (sr_wr_ok_o),
  .sr_wr_rej_o  (sr_wr_rej_o),
  .status_o     (status_o)
);

// File: tb/test_mem_stat_ctrl.sv
module test_mem_stat_ctrl;
  localparam int ADDR_W = 6;
  localparam int NADDR  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        nv_init = 5'b10110;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_op = '0;
  logic [7:0]        cmd_data = '0;
  logic              wp_n = 1'b1;
  logic              arr_req = 1'b0;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic              arr_ok, arr_rej, sr_ok, sr_rej;
  logic [7:0]        status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mem_stat_ctrl #(.ADDR_W(ADDR_W)) i_mem_stat_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .nv_init_i    (nv_init),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_data_i   (cmd_data),
    .wp_ni        (wp_n),
    .arr_wr_req_i (arr_req),
    .arr_addr_i   (arr_addr),
    .arr_wr_ok_o  (arr_ok),
    .arr_wr_rej_o (arr_rej),
    .sr_wr_ok_o   (sr_ok),
    .sr_wr_rej_o  (sr_rej),
    .status_o     (status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] code, input logic [7:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic awr(input int addr);
    @(negedge clk);
    arr_req = 1'b1; arr_addr = addr[ADDR_W-1:0];
    @(negedge clk);
    arr_req = 1'b0;
  endtask

  function automatic logic prot(input int blk, input int addr);
    return (blk == 3) || (blk == 2 && addr >= NADDR / 2) || (blk == 1 && addr >= 3 * NADDR / 4);
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp_st;
    repeat (3) @(negedge clk);
    // R1 R2: pe=1 wd=01 bl=10
    chk("R1 reset status", status, 8'h98);
    chk("R1 reset pulses", {4'h0, arr_ok, arr_rej, sr_ok, sr_rej}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", status, 8'h98);

    // R3 latch set/clear, unknown op
    op(8'h06, 8'h00); chk("R3 wen", status, 8'h99);
    op(8'h55, 8'hFF); chk("R3 unknown op", status, 8'h99);
    op(8'h04, 8'h00); chk("R3 wdis", status, 8'h98);
    // R4 flag
    op(8'h3A, 8'h00); chk("R4 fset", status, 8'h9A);
    op(8'h06, 8'h00); op(8'h3B, 8'h00); chk("R4 fclr", status, 8'h99);
    op(8'h04, 8'h00);

    // R9 collision: flag set ignored, latch set ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h3A; arr_req = 1'b1; arr_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b0; arr_req = 1'b0;
    chk("R9 cmd ignored on collision", status, 8'h98);
    chk("R9 array rejected (wel 0)", {6'h0, arr_ok, arr_rej}, 8'h01);

    // R7 R8 R10: sweep pin, protect-enable, latch; data has junk in bits 6,1,0
    for (int pe = 0; pe < 2; pe++) begin
      for (int wp = 0; wp < 2; wp++) begin
        for (int wel = 0; wel < 2; wel++) begin
          wp_n = 1'b1;
          op(8'h06, 8'h00);
          op(8'h01, {pe[0], 7'b010_0100});
          exp_st = {pe[0], 7'b010_0100};
          chk("R7 setup load", status, exp_st);
          wp_n = wp[0];
          if (wel != 0) op(8'h06, 8'h00);
          @(negedge clk);
          cmd_valid = 1'b1; cmd_op = 8'h01; cmd_data = 8'h7F;
          @(negedge clk);
          cmd_valid = 1'b0;
          if (wel != 0 && !(pe != 0 && wp == 0)) begin
            chk("R7 sr accepted", {6'h0, sr_ok, sr_rej}, 8'h02);
            chk("R7 fields loaded", status, 8'h3C);
          end else begin
            chk("R7 sr rejected", {6'h0, sr_ok, sr_rej}, 8'h01);
            chk("R10 fields held", status, exp_st);
          end
          chk("R8 latch low after sr write", {7'h0, status[0]}, 8'h00);
        end
      end
    end
    wp_n = 1'b1;

    // R5 R6 R8: exhaustive address sweep per lock code
    for (int blk = 0; blk < 4; blk++) begin
      op(8'h06, 8'h00);
      op(8'h01, {4'h0, blk[1:0], 2'b00});
      chk("R5 lock code loaded", status, {4'h0, blk[1:0], 2'b00});
      for (int a = 0; a < NADDR; a++) begin
        for (int wel = 0; wel < 2; wel++) begin
          logic good;
          if (wel != 0) op(8'h06, 8'h00);
          awr(a);
          good = (wel != 0) && !prot(blk, a);
          chk(good ? "R6 R5 accept" : "R6 R5 reject", {6'h0, arr_ok, arr_rej}, {6'h0, good, !good});
          chk("R8 latch low after array write", {7'h0, status[0]}, 8'h00);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule